// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a cycle-accurate, synthesizable model of a small pipelined cache SRAM with a 36-bit word made of four 9-bit byte lanes. Every synchronous input is captured in an input register on the rising clock edge. The access is decoded from those registered values and carried out at the following edge. Read data then leaves through an output register. An access opens on either of two address strobes. The processor strobe always reads and wins when both strobes are low. The controller strobe reads or writes, depending on the write controls.

Once an access is open, cycles with neither strobe low continue the burst. A low advance input steps a 2-bit wrapping counter, and the low two address bits follow a linear or an interleaved order selected by a mode input. Write controls in a continue cycle turn that cycle into a write at the current burst address. Three chip selects decide whether a strobe opens an access or deselects the device. The data output is a plain bus with a separate drive-enable flag. The output enable gates that flag without waiting for a clock. The flag stays low for one cycle after a deselect or a write, so a read that follows either one does not drive early.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is low, and after it is released with no access, `dout_o` is all zeros and `dout_en_o` is low.
- R2: A read whose inputs are captured at edge E presents the word on `dout_o` after edge E+1. `dout_en_o` is high for that cycle when `oe_ni` is low, and `dout_o` holds its value through cycles that are not reads.
- R3: With the device selected, a low `proc_stb_ni` starts a read even when write controls are asserted. It takes priority over a simultaneously low `ctrl_stb_ni`, and the array is left unchanged.
- R4: With the device selected, a low `ctrl_stb_ni` together with asserted write controls writes `din_i` to the captured address at the next edge.
- R5: On a write without the global write, only lanes whose `lane_we_ni` bit is 0 are updated. Lane k is bits 9k+8 down to 9k.
- R6: A low `glob_we_ni` on a write updates all four lanes, whatever `lane_we_ni` holds.
- R7: The device is selected only when `cs1_ni`=0, `cs2_i`=1 and `cs3_ni`=0. A strobe under any other combination is a deselect: nothing is written, the output is undriven in the next cycle, and the burst is closed.
- R8: With `burst_lin_i`=1, each continue cycle with `adv_ni`=0 steps the low two address bits to (start+n) mod 4. The upper bits stay fixed.
- R9: With `burst_lin_i`=0, the low two address bits of the n-th burst step are start XOR n.
- R10: A continue cycle with `adv_ni`=1 repeats the current burst address.
- R11: `oe_ni` high forces `dout_en_o` low at once, with no clock edge needed. Returning it low restores the drive.
- R12: In the first cycle of a read that follows a deselect or a write, `dout_en_o` stays low even with `oe_ni` low.
- R13: A continue cycle with write controls asserted writes `din_i` at the current burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address |
| proc_stb_ni | input | 1 | Processor address strobe, active low |
| ctrl_stb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_ni | input | 1 | Chip select, active low |
| glob_we_ni | input | 1 | Global write of all lanes, active low |
| lane_we_ni | input | LANES | Per-lane write selects, active low |
| burst_lin_i | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_ni | input | 1 | Output enable, asynchronous, active low |
| din_i | input | DW | Write data |
| dout_o | output | DW | Registered read data |
| dout_en_o | output | 1 | Output drive enable |

## Verification
A wrong burst counter or base register shows up one cycle after the faulty step, as a word from the wrong address within the same aligned group of four. Bursts are therefore read back with a distinct value in each slot, in both orders and with a hold. A wrongly held selected state or lane mask corrupts the array without any sign at the write itself. It becomes visible only at the next read of that word, so each write, blocked write and processor-strobe start is followed by a read-back. A stale read flag shows as `dout_en_o` rising one cycle too early, and this is sampled in the mask cycle after every deselect and write.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_DESEL = 2'd1,
    OP_RD    = 2'd2,
    OP_WR    = 2'd3
  } sram_op_e;
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 36,
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             proc_stb_ni,
  input  logic             ctrl_stb_ni,
  input  logic             adv_ni,
  input  logic             cs1_ni,
  input  logic             cs2_i,
  input  logic             cs3_ni,
  input  logic             glob_we_ni,
  input  logic [LANES-1:0] lane_we_ni,
  input  logic             burst_lin_i,
  input  logic [DW-1:0]    din_i,
  output logic [AW-1:0]    addr_q_o,
  output logic             psn_q_o,
  output logic             csn_q_o,
  output logic             advn_q_o,
  output logic             sel_q_o,
  output logic             gwn_q_o,
  output logic [LANES-1:0] bwn_q_o,
  output logic             lin_q_o,
  output logic [DW-1:0]    din_q_o
);
  // chip select decode folded into the input register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o <= '0;
      psn_q_o  <= 1'b1;
      csn_q_o  <= 1'b1;
      advn_q_o <= 1'b1;
      sel_q_o  <= 1'b0;
      gwn_q_o  <= 1'b1;
      bwn_q_o  <= '1;
      lin_q_o  <= 1'b1;
      din_q_o  <= '0;
    end else begin
      addr_q_o <= addr_i;
      psn_q_o  <= proc_stb_ni;
      csn_q_o  <= ctrl_stb_ni;
      advn_q_o <= adv_ni;
      sel_q_o  <= ~cs1_ni & cs2_i & ~cs3_ni;
      gwn_q_o  <= glob_we_ni;
      bwn_q_o  <= lane_we_ni;
      lin_q_o  <= burst_lin_i;
      din_q_o  <= din_i;
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic          linear_i,
  input  logic [CW-1:0] base_i,
  output logic [CW-1:0] lo_o
);
  logic [CW-1:0] cnt_q, cnt_nx, base_q, base_nx;

  assign cnt_nx  = start_i ? '0 : (adv_i ? cnt_q + 1'b1 : cnt_q);
  assign base_nx = start_i ? base_i : base_q;
  assign lo_o    = linear_i ? (base_nx + cnt_nx) : (base_nx ^ cnt_nx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      base_q <= '0;
    end else begin
      cnt_q  <= cnt_nx;
      base_q <= base_nx;
    end
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic [LANES-1:0] we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end
    assign rdata_o[l*LANE_W +: LANE_W] = mem[addr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             proc_stb_ni,
  input  logic             ctrl_stb_ni,
  input  logic             adv_ni,
  input  logic             cs1_ni,
  input  logic             cs2_i,
  input  logic             cs3_ni,
  input  logic             glob_we_ni,
  input  logic [LANES-1:0] lane_we_ni,
  input  logic             burst_lin_i,
  input  logic             oe_ni,
  input  logic [DW-1:0]    din_i,
  output logic [DW-1:0]    dout_o,
  output logic             dout_en_o
);
  localparam int unsigned CW = 2;

  logic [AW-1:0]    addr_q;
  logic             psn_q, csn_q, advn_q, sel_q, gwn_q, lin_q;
  logic [LANES-1:0] bwn_q;
  logic [DW-1:0]    din_q;

  sram_in_stage #(.AW(AW), .DW(DW), .LANES(LANES)) u_in (
    .clk_i, .rst_ni, .addr_i, .proc_stb_ni, .ctrl_stb_ni, .adv_ni,
    .cs1_ni, .cs2_i, .cs3_ni, .glob_we_ni, .lane_we_ni, .burst_lin_i, .din_i,
    .addr_q_o(addr_q), .psn_q_o(psn_q), .csn_q_o(csn_q), .advn_q_o(advn_q),
    .sel_q_o(sel_q), .gwn_q_o(gwn_q), .bwn_q_o(bwn_q), .lin_q_o(lin_q),
    .din_q_o(din_q)
  );

  sram_op_e         op;
  logic             start, adv, wr_req, active_q;
  logic [AW-CW-1:0] hi_q;
  logic [CW-1:0]    lo;
  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] lane_we;
  logic [DW-1:0]    rdata;
  logic             rd_q;
  logic [DW-1:0]    dout_q;

  assign wr_req = ~gwn_q | (bwn_q != '1);

  // processor strobe first, then controller strobe, then burst continue
  always_comb begin
    op    = OP_IDLE;
    start = 1'b0;
    adv   = 1'b0;
    if (!psn_q) begin
      start = sel_q;
      op    = sel_q ? OP_RD : OP_DESEL;
    end else if (!csn_q) begin
      start = sel_q;
      op    = sel_q ? (wr_req ? OP_WR : OP_RD) : OP_DESEL;
    end else if (active_q) begin
      adv = ~advn_q;
      op  = wr_req ? OP_WR : OP_RD;
    end
  end

  burst_addr_seq #(.CW(CW)) u_seq (
    .clk_i, .rst_ni,
    .start_i (start),
    .adv_i   (adv),
    .linear_i(lin_q),
    .base_i  (addr_q[CW-1:0]),
    .lo_o    (lo)
  );

  assign acc_addr = {(start ? addr_q[AW-1:CW] : hi_q), lo};
  assign lane_we  = (op == OP_WR) ? (gwn_q ? ~bwn_q : '1) : '0;

  sram_lane_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i,
    .we_i   (lane_we),
    .addr_i (acc_addr),
    .wdata_i(din_q),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hi_q     <= '0;
      rd_q     <= 1'b0;
      dout_q   <= '0;
    end else begin
      if (start) begin
        active_q <= 1'b1;
        hi_q     <= addr_q[AW-1:CW];
      end else if (op == OP_DESEL) begin
        active_q <= 1'b0;
      end
      rd_q <= (op == OP_RD);
      if (op == OP_RD) dout_q <= rdata;
    end
  end

  assign dout_o    = dout_q;
  assign dout_en_o = ~oe_ni & rd_q;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk
  import sram_pkg::*;
#(
  parameter int unsigned DW    = 36,
  parameter int unsigned LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             oe_ni,
  input logic             dout_en_o,
  input logic [DW-1:0]    dout_o,
  input sram_op_e         op_i,
  input logic             psn_q_i,
  input logic             sel_q_i,
  input logic             gwn_q_i,
  input logic [LANES-1:0] lane_we_i
);
  always_comb begin
    if (rst_ni && oe_ni) AST_OE_FORCES_OFF: assert (!dout_en_o); // R11
  end

  AST_PROC_STARTS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psn_q_i && sel_q_i) |-> (op_i == OP_RD)); // R3

  AST_DESEL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DESEL) |-> (lane_we_i == '0)); // R7

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_WR && !gwn_q_i) |-> (&lane_we_i)); // R6

  AST_MASK_AFTER_NON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_RD) |=> !dout_en_o); // R12

  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RD) |=> (oe_ni || dout_en_o)); // R2

  AST_DOUT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_RD) |=> $stable(dout_o)); // R2
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.DW(DW), .LANES(LANES)) u_chk (
  .clk_i, .rst_ni, .oe_ni, .dout_en_o, .dout_o,
  .op_i     (op),
  .psn_q_i  (psn_q),
  .sel_q_i  (sel_q),
  .gwn_q_i  (gwn_q),
  .lane_we_i(lane_we)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        psn, csn, advn, cs1n, cs2, cs3n, gwn, lin, oen;
  logic [3:0]  bwn;
  logic [35:0] din, dout;
  logic        den;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_stb_ni(psn),
    .ctrl_stb_ni(csn), .adv_ni(advn), .cs1_ni(cs1n), .cs2_i(cs2), .cs3_ni(cs3n),
    .glob_we_ni(gwn), .lane_we_ni(bwn), .burst_lin_i(lin), .oe_ni(oen),
    .din_i(din), .dout_o(dout), .dout_en_o(den)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic        g;
    logic [3:0]  b;
    logic [35:0] d;
    logic [35:0] e;
  } vec_t;

  // R4 R5 R6: writes and read-backs through the controller strobe
  localparam vec_t VEC [9] = '{
    '{1'b1, 8'h10, 1'b0, 4'hF, 36'h123456789, 36'h0},
    '{1'b0, 8'h10, 1'b1, 4'hF, 36'h0,         36'h123456789},
    '{1'b1, 8'h10, 1'b1, 4'hE, 36'hFFFFFFFFF, 36'h0},
    '{1'b0, 8'h10, 1'b1, 4'hF, 36'h0,         36'h1234567FF},
    '{1'b1, 8'h20, 1'b0, 4'hF, 36'h0AAAAAAAA, 36'h0},
    '{1'b1, 8'h20, 1'b1, 4'h7, 36'h000000000, 36'h0},
    '{1'b0, 8'h20, 1'b1, 4'hF, 36'h0,         36'h002AAAAAA},
    '{1'b1, 8'h30, 1'b0, 4'hD, 36'h987654321, 36'h0},
    '{1'b0, 8'h30, 1'b1, 4'hF, 36'h0,         36'h987654321}
  };

  task automatic chk36(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout_en actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_desel();
    psn = 1'b1; csn = 1'b0; cs1n = 1'b1; cs2 = 1'b1; cs3n = 1'b0;
    advn = 1'b1; gwn = 1'b1; bwn = 4'hF;
  endtask

  task automatic set_ctrl(input logic [7:0] a, input logic g, input logic [3:0] b,
                          input logic [35:0] d);
    psn = 1'b1; csn = 1'b0; cs1n = 1'b0; cs2 = 1'b1; cs3n = 1'b0;
    advn = 1'b1; addr = a; gwn = g; bwn = b; din = d;
  endtask

  task automatic set_cont(input logic av, input logic g, input logic [3:0] b,
                          input logic [35:0] d);
    psn = 1'b1; csn = 1'b1; advn = av; gwn = g; bwn = b; din = d;
  endtask

  task automatic write1(input logic [7:0] a, input logic [35:0] d);
    set_ctrl(a, 1'b0, 4'hF, d);
    step();
    set_desel();
    step();
  endtask

  task automatic read1(input logic [7:0] a, input logic [35:0] e, input string req);
    set_ctrl(a, 1'b1, 4'hF, 36'h0);
    step();
    chk1("R12 mask after deselect", den, 1'b0);
    set_desel();
    step();
    chk36(req, dout, e);
    chk1("R2 drive on read", den, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; din = '0; lin = 1'b1; oen = 1'b0;
    set_desel();
    repeat (3) @(negedge clk);
    chk36("R1 reset dout", dout, 36'h0);
    chk1("R1 reset drive", den, 1'b0);
    rst_n = 1'b1;
    step();
    chk36("R1 after reset dout", dout, 36'h0);
    chk1("R1 after reset drive", den, 1'b0);

    for (int i = 0; i < 9; i++) begin
      if (VEC[i].wr) begin
        set_ctrl(VEC[i].a, VEC[i].g, VEC[i].b, VEC[i].d);
        step();
        set_desel();
        step();
      end else begin
        read1(VEC[i].a, VEC[i].e, "R4/R5/R6 vector read");
      end
    end

    // R3: processor strobe wins and reads despite write controls
    write1(8'h40, 36'h111111111);
    set_ctrl(8'h40, 1'b0, 4'h0, 36'h222222222);
    psn = 1'b0;
    step();
    set_desel();
    step();
    chk36("R3 proc strobe read", dout, 36'h111111111);
    read1(8'h40, 36'h111111111, "R3 array unchanged");

    // R7: each non-selecting chip select blocks the write
    for (int k = 0; k < 3; k++) begin
      set_ctrl(8'h40, 1'b0, 4'hF, 36'h333333333);
      if (k == 0) cs1n = 1'b1;
      if (k == 1) cs2 = 1'b0;
      if (k == 2) cs3n = 1'b1;
      step();
      set_desel();
      step();
      chk1("R7 undriven after deselect", den, 1'b0);
      read1(8'h40, 36'h111111111, "R7 no write when deselected");
    end

    for (int j = 0; j < 4; j++) write1(8'h50 + 8'(j), 36'h500 + 36'(j));

    // R8: linear burst from 0x52
    lin = 1'b1;
    set_ctrl(8'h52, 1'b1, 4'hF, 36'h0);
    step();
    set_cont(1'b0, 1'b1, 4'hF, 36'h0);
    step(); chk36("R8 linear step0", dout, 36'h502);
    step(); chk36("R8 linear step1", dout, 36'h503);
    step(); chk36("R8 linear wrap", dout, 36'h500);
    set_desel();
    step(); chk36("R8 linear step3", dout, 36'h501);
    step();

    // R9: interleaved burst from 0x51
    lin = 1'b0;
    set_ctrl(8'h51, 1'b1, 4'hF, 36'h0);
    step();
    set_cont(1'b0, 1'b1, 4'hF, 36'h0);
    step(); chk36("R9 interleave step0", dout, 36'h501);
    step(); chk36("R9 interleave step1", dout, 36'h500);
    step(); chk36("R9 interleave step2", dout, 36'h503);
    set_desel();
    step(); chk36("R9 interleave step3", dout, 36'h502);
    step();

    // R10: advance high holds the address
    lin = 1'b1;
    set_ctrl(8'h51, 1'b1, 4'hF, 36'h0);
    step();
    set_cont(1'b1, 1'b1, 4'hF, 36'h0);
    step(); chk36("R10 start", dout, 36'h501);
    set_cont(1'b0, 1'b1, 4'hF, 36'h0);
    step(); chk36("R10 hold", dout, 36'h501);
    set_desel();
    step(); chk36("R10 advance after hold", dout, 36'h502);
    step();

    // R13: burst write through continue cycle
    set_ctrl(8'h60, 1'b0, 4'hF, 36'h0A0A0A0A0);
    step();
    set_cont(1'b0, 1'b0, 4'hF, 36'h0A1A1A1A1);
    step();
    set_desel();
    step();
    read1(8'h61, 36'h0A1A1A1A1, "R13 burst write step");
    read1(8'h60, 36'h0A0A0A0A0, "R13 burst write start");

    // R11: asynchronous output enable
    oen = 1'b1;
    #1 chk1("R11 oe high off", den, 1'b0);
    oen = 1'b0;
    #1 chk1("R11 oe low restores", den, 1'b1);

    // R12: read right after a write is masked for one cycle
    set_ctrl(8'h70, 1'b0, 4'hF, 36'h0C0FFEE11);
    step();
    set_ctrl(8'h70, 1'b1, 4'hF, 36'h0);
    step();
    chk1("R12 mask after write", den, 1'b0);
    set_desel();
    step();
    chk36("R12 read after write", dout, 36'h0C0FFEE11);
    chk1("R12 drive restored", den, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule